// File: doc/BRIEF.md
# Parallel Transaction Commit Arbiter

This block sits at the centre of a group of cores that run hardware transactions and decides which of them may broadcast their commits. Each core that has reached the end of a transaction raises a request and presents two fixed-width Bloom-style bit vectors. One summarizes the line addresses it read and the other the line addresses it wrote. The arbiter grants commit permission to a core only when that core cannot conflict with any transaction that is already committing. Several disjoint commits can therefore proceed side by side instead of one at a time.

A granted core keeps its grant until it raises its done signal, which marks the end of its write-address broadcast. At the moment of the grant the arbiter captures the core's signatures and uses that copy for all later conflict checks. Only one new grant is issued per cycle, so two newcomers are never admitted without being checked against each other. Candidates are scanned in a rotating order that begins just after the most recently granted core, which prevents starvation.

Top module: `commit_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every bit of `grant_o` is 0.
- R2: A grant bit rises only in the cycle after its core's `req_i` bit was 1.
- R3: At most one bit of `grant_o` rises per clock cycle.
- R4: A grant stays 1 for as long as that core's `done_i` bit is 0, whatever that core's request and signature inputs do.
- R5: When `done_i` is sampled 1 for a granted core, its grant is 0 in the next cycle. In that same sampling cycle the core already counts as no longer committing, so a requester it was blocking can be granted at that edge.
- R6: A requester is refused while the bitwise AND of its write signature with the read signature OR the write signature of any committing core is nonzero.
- R7: A requester is refused while the bitwise AND of its read signature with the write signature of any committing core is nonzero.
- R8: Overlap between read signatures alone never blocks a grant, so cores with read-only overlap commit concurrently.
- R9: Among eligible requesters, the new grant goes to the first one in increasing index order, with wrap-around, starting from the index just after the last core granted. After reset the last core granted is taken to be core 0.
- R10: The signatures used for a committing core are those present on its inputs in the cycle it was granted. Later changes on those inputs have no effect.
- R11: When no core is committing and some non-granted core requests, a new grant appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | N_CORES | Per-core commit request |
| rsig_i | input | N_CORES*SIG_W | Read signatures; core k occupies bits [k*SIG_W +: SIG_W] |
| wsig_i | input | N_CORES*SIG_W | Write signatures; core k occupies bits [k*SIG_W +: SIG_W] |
| done_i | input | N_CORES | Per-core end of commit broadcast |
| grant_o | output | N_CORES | Per-core commit permission, held until done |

## Verification
The state of the arbiter is visible at the ports through `grant_o`. A stale or corrupted captured signature shows up as a wrong grant or a wrong refusal one cycle after the next request that overlaps it. A wrong rotation pointer shows up as a different grant order on the next contended handover. A slot that fails to release shows up as a grant that survives `done_i`, and it also blocks requesters that should have been admitted. Every such fault therefore reaches the outputs within one or two cycles of the stimulus that exposes it. The sweep covers every pairing of a committing core's signatures with a wide range of requester signatures, so each conflict rule is tested on both sides of its boundary.

// File: rtl/commit_arb_pkg.sv
// Package: shared defaults for the parallel commit arbiter.
// Assumes: nothing; holds only constants used as parameter defaults.
package commit_arb_pkg;
    localparam int unsigned DEF_CORES = 4;
    localparam int unsigned DEF_SIG_W = 16;
endpackage

// File: rtl/commit_slot.sv
// Module: one per-core commit slot. Holds the grant and the signatures
// captured at grant time until the core reports its broadcast is done.
// Assumes: load_i is only raised while the slot is idle.
module commit_slot #(
    parameter int unsigned SIG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             done_i,
    input  logic [SIG_W-1:0] rsig_i,
    input  logic [SIG_W-1:0] wsig_i,
    output logic             busy_o,
    output logic             live_o,
    output logic [SIG_W-1:0] rsig_q_o,
    output logic [SIG_W-1:0] wsig_q_o
);
    logic             busy_q;
    logic [SIG_W-1:0] rsig_q;
    logic [SIG_W-1:0] wsig_q;

    // Grant flag and signature capture for this core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            rsig_q <= '0;
            wsig_q <= '0;
        end else if (load_i) begin
            busy_q <= 1'b1;
            rsig_q <= rsig_i;
            wsig_q <= wsig_i;
        end else if (done_i) begin
            busy_q <= 1'b0;
        end
    end

    // A slot whose done is sampled this cycle no longer counts as committing.
    always_comb begin
        live_o = busy_q & ~done_i;
    end

    assign busy_o   = busy_q;
    assign rsig_q_o = rsig_q;
    assign wsig_q_o = wsig_q;

    // R4: grant held while done is low.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !done_i |=> busy_q);

    // R5: grant released after done is sampled.
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && done_i |=> !busy_q);

    // R10: captured signatures do not move while the slot stays held.
    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !done_i |=> $stable(rsig_q) && $stable(wsig_q));
endmodule

// File: rtl/commit_conflict.sv
// Module: possible-conflict test of one candidate against all live slots.
// A write/read or write/write bit overlap blocks; read/read does not.
// Assumes: signatures are Bloom-style, so false positives are acceptable.
module commit_conflict #(
    parameter int unsigned N_CORES = 4,
    parameter int unsigned SIG_W   = 16
) (
    input  logic [SIG_W-1:0]              cand_r_i,
    input  logic [SIG_W-1:0]              cand_w_i,
    input  logic [N_CORES-1:0]            live_i,
    input  logic [N_CORES-1:0][SIG_W-1:0] held_r_i,
    input  logic [N_CORES-1:0][SIG_W-1:0] held_w_i,
    output logic                          blocked_o
);
    logic [N_CORES-1:0] hit;

    for (genvar j = 0; j < N_CORES; j++) begin : g_vs
        // Overlap test against committing slot j.
        always_comb begin
            hit[j] = live_i[j] &
                     ((|(cand_w_i & (held_r_i[j] | held_w_i[j]))) |
                      (|(cand_r_i & held_w_i[j])));
        end
    end

    assign blocked_o = |hit;
endmodule

// File: rtl/commit_rr_pick.sv
// Module: rotating first-eligible picker. Scans from the index after
// last_i, wrapping, and returns the first eligible core.
// Assumes: N_CORES >= 2.
module commit_rr_pick #(
    parameter int unsigned N_CORES = 4,
    localparam int unsigned IW     = $clog2(N_CORES)
) (
    input  logic [N_CORES-1:0] elig_i,
    input  logic [IW-1:0]      last_i,
    output logic               valid_o,
    output logic [IW-1:0]      idx_o
);
    // Wrap-around scan for the first eligible core.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int off = 1; off <= int'(N_CORES); off++) begin
            int c;
            c = (int'(last_i) + off) % int'(N_CORES);
            if (!valid_o && elig_i[c]) begin
                valid_o = 1'b1;
                idx_o   = IW'(c);
            end
        end
    end
endmodule

// File: rtl/commit_arbiter.sv
// Module: central arbiter for parallel transaction commits. Admits at most
// one new committer per cycle, only if its signatures cannot conflict with
// any live committer, and scans requesters in rotating order.
// Assumes: each core holds req until granted and pulses done when its
// write broadcast has finished.
module commit_arbiter #(
    parameter int unsigned N_CORES = commit_arb_pkg::DEF_CORES,
    parameter int unsigned SIG_W   = commit_arb_pkg::DEF_SIG_W,
    localparam int unsigned IW     = $clog2(N_CORES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_CORES-1:0]         req_i,
    input  logic [N_CORES*SIG_W-1:0]   rsig_i,
    input  logic [N_CORES*SIG_W-1:0]   wsig_i,
    input  logic [N_CORES-1:0]         done_i,
    output logic [N_CORES-1:0]         grant_o
);
    logic [N_CORES-1:0]            busy;
    logic [N_CORES-1:0]            live;
    logic [N_CORES-1:0]            blocked;
    logic [N_CORES-1:0]            elig;
    logic [N_CORES-1:0]            load;
    logic [N_CORES-1:0][SIG_W-1:0] held_r;
    logic [N_CORES-1:0][SIG_W-1:0] held_w;
    logic                          pick_v;
    logic [IW-1:0]                 pick_idx;
    logic [IW-1:0]                 last_q;

    for (genvar k = 0; k < N_CORES; k++) begin : g_core
        commit_slot #(.SIG_W(SIG_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (load[k]),
            .done_i   (done_i[k]),
            .rsig_i   (rsig_i[k*SIG_W +: SIG_W]),
            .wsig_i   (wsig_i[k*SIG_W +: SIG_W]),
            .busy_o   (busy[k]),
            .live_o   (live[k]),
            .rsig_q_o (held_r[k]),
            .wsig_q_o (held_w[k])
        );

        commit_conflict #(.N_CORES(N_CORES), .SIG_W(SIG_W)) u_chk (
            .cand_r_i  (rsig_i[k*SIG_W +: SIG_W]),
            .cand_w_i  (wsig_i[k*SIG_W +: SIG_W]),
            .live_i    (live),
            .held_r_i  (held_r),
            .held_w_i  (held_w),
            .blocked_o (blocked[k])
        );

        // A core may be admitted if it asks, is idle and is conflict-free.
        always_comb begin
            elig[k] = req_i[k] & ~busy[k] & ~blocked[k];
            load[k] = pick_v && (pick_idx == IW'(k));
        end
    end

    commit_rr_pick #(.N_CORES(N_CORES)) u_pick (
        .elig_i  (elig),
        .last_i  (last_q),
        .valid_o (pick_v),
        .idx_o   (pick_idx)
    );

    // Rotation pointer: remembers the most recently granted core.
    always_ff @(posedge clk) begin
        if (!rst_n)      last_q <= '0;
        else if (pick_v) last_q <= pick_idx;
    end

    assign grant_o = busy;

    // R2: a rising grant needs a request in the previous cycle.
    a_r2_req_needed: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~$past(grant_o) & ~$past(req_i)) == '0);

    // R3: never more than one new grant per cycle.
    a_r3_single_new: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o & ~$past(grant_o)) <= 1);

    // R11: idle arbiter with a waiting requester grants next cycle.
    a_r11_progress: assert property (@(posedge clk) disable iff (!rst_n)
        (live == '0) && ((req_i & ~grant_o) != '0) |=> (grant_o & ~$past(grant_o)) != '0);

    // R6 and R7: no two concurrent committers may possibly conflict.
    for (genvar i = 0; i < N_CORES; i++) begin : g_pair_i
        for (genvar j = 0; j < N_CORES; j++) begin : g_pair_j
            if (i != j) begin : g_ne
                a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
                    busy[i] && busy[j] |-> (held_w[i] & (held_r[j] | held_w[j])) == '0);
            end
        end
    end
endmodule

// File: tb/test_commit_arbiter.sv
`timescale 1ns/1ps
module test_commit_arbiter;
    localparam int NC = 4;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] req = '0;
    logic [NC-1:0] done = '0;
    logic [NC*SW-1:0] rsig = '0;
    logic [NC*SW-1:0] wsig = '0;
    logic [NC-1:0] grant;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    commit_arbiter #(.N_CORES(NC), .SIG_W(SW)) i_commit_arbiter (
        .clk(clk), .rst_n(rst_n), .req_i(req), .rsig_i(rsig),
        .wsig_i(wsig), .done_i(done), .grant_o(grant)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        step(); step();
        chk("R1 during reset", 32'(grant), 0);
        @(negedge clk); rst_n = 1'b1;
        step();
        chk("R1 after reset", 32'(grant), 0);

        // Sweep: core 0 commits with (a,b), core 1 asks with (c,d)
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 16; y++) begin
                logic [SW-1:0] a, b, c, d;
                logic g1;
                a = x[3:0]; b = x[7:4]; c = 4'(y); d = 4'(y * 3);
                g1 = ((d & (a | b)) == 0) && ((c & b) == 0);
                @(negedge clk);
                req = 4'b0001; rsig[3:0] = a; wsig[3:0] = b;
                step();
                chk("R11 idle grant core0", 32'(grant), 32'h1);
                @(negedge clk);
                req = 4'b0010; rsig[3:0] = ~a; wsig[3:0] = ~b;
                rsig[7:4] = c; wsig[7:4] = d;
                step();
                // R6 R7 R8 R10 conflict decision on captured signatures; R4 hold
                chk("R6/R7/R8/R10 decision", 32'(grant), {30'd0, g1, 1'b1});
                @(negedge clk);
                done = {2'b00, g1, 1'b1};
                step();
                // R5: release and same-cycle admission of the blocked core
                chk("R5 release handover", 32'(grant), {30'd0, ~g1, 1'b0});
                @(negedge clk);
                req = '0; done = {2'b00, ~g1, 1'b0};
                step();
                chk("R2 no request no grant", 32'(grant), 0);
                @(negedge clk);
                done = '0; rsig = '0; wsig = '0;
            end
        end

        // Set pointer to core 2
        @(negedge clk); req = 4'b0100;
        step();
        chk("R11 single requester", 32'(grant), 32'h4);
        @(negedge clk); req = '0; done = 4'b0100;
        step();
        chk("R5 release", 32'(grant), 0);

        // R9: all write everything; rotation 3,0,1,2
        @(negedge clk); done = '0; req = 4'b1111; wsig = 16'hFFFF;
        step();
        chk("R9 first after core2", 32'(grant), 32'h8);
        begin
            int order[4] = '{3, 0, 1, 2};
            for (int s = 0; s < 3; s++) begin
                @(negedge clk);
                req[order[s]] = 1'b0; done = 4'(1 << order[s]);
                step();
                chk("R9 rotation handover", 32'(grant), 32'(1 << order[s+1]));
            end
        end
        @(negedge clk); req = '0; done = 4'b0100;
        step();
        chk("R5 last release", 32'(grant), 0);

        // R3 and R8: read-only overlap, one new grant per cycle from core 3
        @(negedge clk); done = '0; wsig = '0; rsig = 16'hFFFF; req = 4'b1111;
        step(); chk("R3 one new grant c1", 32'(grant), 32'h8);
        step(); chk("R3 one new grant c2", 32'(grant), 32'h9);
        step(); chk("R8 read overlap c3", 32'(grant), 32'hB);
        step(); chk("R8 read overlap c4", 32'(grant), 32'hF);
        @(negedge clk); req = '0; done = 4'b1111;
        step(); chk("R5 all released", 32'(grant), 0);
        @(negedge clk); done = '0;
        step(); chk("R2 idle stays idle", 32'(grant), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule